// File: doc/BRIEF.md
# Virtual Interrupt Acknowledge Interface

This block is the guest-facing side of a virtualised interrupt controller for a single virtual processor. A hypervisor fills four list entries, each describing one virtual interrupt: its ID, the CPU that sent it, a priority and a lifecycle state. The guest does not see wires from interrupt sources. It reads an acknowledge register to claim the most urgent pending entry, then writes an end-of-interrupt register with the same ID and source CPU to retire that entry.

The guest side is a 32-bit register port with a byte address, a read strobe, a write strobe, write data and registered read data. Four registers are decoded: control at 0x0 (bit 0 enables the interface; all 32 bits are stored), priority mask at 0x4 (5 bits, held for the guest), acknowledge at 0x8 (read) and end-of-interrupt at 0xC (write). The hypervisor side loads whole entries by index and reads any entry back through a combinational port.

A two-state machine drives the level-sensitive `virq` output. In QUIET the output is low. The post transition moves QUIET to RAISED when some entry is pending and the interface is enabled. In RAISED the output is high. The withdraw transition moves RAISED to QUIET once no entry is pending. Clearing the enable while in RAISED does not withdraw the request.

Top module: `virq_ack_if`

## Requirements
- R1: After reset every list entry reads 0, the control register reads 0, `reg_rdata` is 0 and `virq` is low.
- R2: A write to control (0x0) stores all 32 bits and a write to the priority mask (0x4) stores bits [4:0]. A read of either returns the stored value, with the other mask bits 0, on `reg_rdata` in the cycle after the strobe.
- R3: An acknowledge read (0x8) returns 1023 and changes no entry when no entry is pending or control bit 0 is clear.
- R4: Entry layout: ID [9:0], source CPU [12:10], priority [27:23], state [29:28] with 0 invalid, 1 pending, 2 active, 3 pending and active. An entry is pending when its state is 1 or 3. A successful acknowledge returns the source CPU in bits [12:10] and the ID in bits [9:0], with bits [31:13] 0, and sets the chosen entry's state to 2.
- R5: The acknowledge picks the pending entry with the numerically lowest priority. A tie goes to the lowest index.
- R6: An end-of-interrupt write (0xC) takes an ID from bits [9:0] and a source CPU from bits [12:10]. It sets to 0 the state of the lowest-index entry whose state is non-zero and whose ID and CPU both match. Every other field is kept.
- R7: An end-of-interrupt write that matches no non-invalid entry changes no entry.
- R8: `virq` rises one cycle after an entry is pending while control bit 0 is set. It stays low while the interface is disabled.
- R9: Once high, `virq` stays high while any entry is pending, even if control bit 0 is cleared. It falls one cycle after no entry is pending.
- R10: A hypervisor load writes the whole entry in one clock and wins over a guest acknowledge or end-of-interrupt to the same entry in the same cycle. The acknowledge data still reflects the entry as it was before the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | AW | Guest register byte address |
| reg_rd | input | 1 | Guest read strobe |
| reg_wr | input | 1 | Guest write strobe |
| reg_wdata | input | 32 | Guest write data |
| reg_rdata | output | 32 | Registered guest read data |
| lr_wr_en | input | 1 | Hypervisor entry load strobe |
| lr_wr_idx | input | IW | Index of the entry to load |
| lr_wr_data | input | 32 | Entry value to load |
| lr_rd_idx | input | IW | Index of the entry to read back |
| lr_rd_data | output | 32 | Combinational entry read-back |
| virq | output | 1 | Level virtual interrupt request |

## Verification
A wrong entry state shows up at the ports in one of three ways. A stale pending bit makes the next acknowledge return an already claimed ID instead of 1023. A lost transition shows in the hypervisor read-back on the cycle after the access. A wrong state-machine state shows on `virq` exactly one cycle after the pending set changes. The checks sample each of these at that cycle, so an error in the priority order, in the match on ID and CPU, or in the hold-while-pending rule is caught at the first access that exposes it.

// File: rtl/vif_pkg.sv
package vif_pkg;

    localparam int REG_W    = 32;
    localparam int VID_LSB  = 0;
    localparam int VID_W    = 10;
    localparam int CPU_LSB  = 10;
    localparam int CPU_W    = 3;
    localparam int PRIO_LSB = 23;
    localparam int PRIO_W   = 5;
    localparam int ST_LSB   = 28;

    localparam int OFS_CTRL = 0;
    localparam int OFS_PMR  = 4;
    localparam int OFS_ACK  = 8;
    localparam int OFS_EOI  = 12;

    localparam logic [REG_W-1:0] NO_INTR = 32'd1023;

    typedef enum logic [1:0] {
        LR_INVALID  = 2'd0,
        LR_PENDING  = 2'd1,
        LR_ACTIVE   = 2'd2,
        LR_PEND_ACT = 2'd3
    } lr_state_e;

    typedef enum logic {
        VQ_QUIET  = 1'b0,
        VQ_RAISED = 1'b1
    } virq_state_e;

endpackage

// File: rtl/vif_lr_bank.sv
module vif_lr_bank
    import vif_pkg::*;
#(
    parameter int NUM_LR = 4,
    parameter int IW     = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hyp_we,
    input  logic [IW-1:0]    hyp_idx,
    input  logic [REG_W-1:0] hyp_data,
    input  logic             ack_go,
    input  logic [IW-1:0]    ack_idx,
    input  logic             eoi_go,
    input  logic [IW-1:0]    eoi_idx,
    output logic [REG_W-1:0] lr_q [NUM_LR]
);

    for (genvar g = 0; g < NUM_LR; g++) begin : g_ent
        logic [REG_W-1:0] ent_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ent_q <= '0;
            end else if (hyp_we && (hyp_idx == IW'(g))) begin
                ent_q <= hyp_data;
            end else if (eoi_go && (eoi_idx == IW'(g))) begin
                ent_q[ST_LSB +: 2] <= LR_INVALID;
            end else if (ack_go && (ack_idx == IW'(g))) begin
                ent_q[ST_LSB +: 2] <= LR_ACTIVE;
            end
        end

        assign lr_q[g] = ent_q;
    end

endmodule

// File: rtl/vif_pick.sv
module vif_pick #(
    parameter int NUM_LR = 4,
    parameter int IW     = 2,
    parameter int PW     = 5
) (
    input  logic [NUM_LR-1:0] pend,
    input  logic [PW-1:0]     prio [NUM_LR],
    output logic              valid,
    output logic [IW-1:0]     idx
);

    logic [PW-1:0] best;

    always_comb begin
        valid = 1'b0;
        idx   = '0;
        best  = '1;
        for (int i = 0; i < NUM_LR; i++) begin
            if (pend[i] && (!valid || (prio[i] < best))) begin
                valid = 1'b1;
                idx   = IW'(i);
                best  = prio[i];
            end
        end
    end

endmodule

// File: rtl/vif_eoi_match.sv
module vif_eoi_match #(
    parameter int NUM_LR = 4,
    parameter int IW     = 2,
    parameter int VW     = 10,
    parameter int CW     = 3
) (
    input  logic [NUM_LR-1:0] live,
    input  logic [VW-1:0]     vid [NUM_LR],
    input  logic [CW-1:0]     cpu [NUM_LR],
    input  logic [VW-1:0]     q_vid,
    input  logic [CW-1:0]     q_cpu,
    output logic              hit,
    output logic [IW-1:0]     idx
);

    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = 0; i < NUM_LR; i++) begin
            if (!hit && live[i] && (vid[i] == q_vid) && (cpu[i] == q_cpu)) begin
                hit = 1'b1;
                idx = IW'(i);
            end
        end
    end

endmodule

// File: rtl/vif_virq_fsm.sv
module vif_virq_fsm
    import vif_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pend_any,
    input  logic en,
    output logic virq
);

    virq_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= VQ_QUIET;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            VQ_QUIET:  if (pend_any && en) state_d = VQ_RAISED;
            VQ_RAISED: if (!pend_any)      state_d = VQ_QUIET;
        endcase
    end

    always_comb begin
        virq = (state_q == VQ_RAISED);
    end

endmodule

// File: rtl/virq_ack_if.sv
module virq_ack_if
    import vif_pkg::*;
#(
    parameter int NUM_LR = 4,
    parameter int AW     = 4,
    localparam int IW    = (NUM_LR > 1) ? $clog2(NUM_LR) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    reg_addr,
    input  logic             reg_rd,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             lr_wr_en,
    input  logic [IW-1:0]    lr_wr_idx,
    input  logic [REG_W-1:0] lr_wr_data,
    input  logic [IW-1:0]    lr_rd_idx,
    output logic [REG_W-1:0] lr_rd_data,
    output logic             virq
);

    localparam logic [AW-1:0] A_CTRL = AW'(OFS_CTRL);
    localparam logic [AW-1:0] A_PMR  = AW'(OFS_PMR);
    localparam logic [AW-1:0] A_ACK  = AW'(OFS_ACK);
    localparam logic [AW-1:0] A_EOI  = AW'(OFS_EOI);

    logic [REG_W-1:0]  lr_q [NUM_LR];
    logic [NUM_LR-1:0] pend_vec;
    logic [NUM_LR-1:0] live_vec;
    logic [PRIO_W-1:0] prio_arr [NUM_LR];
    logic [VID_W-1:0]  vid_arr  [NUM_LR];
    logic [CPU_W-1:0]  cpu_arr  [NUM_LR];
    logic [2*NUM_LR-1:0] lr_state_flat;

    for (genvar g = 0; g < NUM_LR; g++) begin : g_fld
        assign pend_vec[g]  = lr_q[g][ST_LSB];
        assign live_vec[g]  = |lr_q[g][ST_LSB +: 2];
        assign prio_arr[g]  = lr_q[g][PRIO_LSB +: PRIO_W];
        assign vid_arr[g]   = lr_q[g][VID_LSB +: VID_W];
        assign cpu_arr[g]   = lr_q[g][CPU_LSB +: CPU_W];
        assign lr_state_flat[2*g +: 2] = lr_q[g][ST_LSB +: 2];
    end

    logic [REG_W-1:0]  ctrl_q;
    logic [PRIO_W-1:0] pmr_q;
    logic [REG_W-1:0]  rdata_q;
    logic [REG_W-1:0]  rd_next;
    logic              ctrl_en;

    logic sel_ctrl, sel_pmr, sel_ack, sel_eoi;
    logic pick_valid, eoi_hit, ack_go, eoi_go;
    logic [IW-1:0] pick_idx, eoi_idx;

    assign ctrl_en  = ctrl_q[0];
    assign sel_ctrl = (reg_addr == A_CTRL);
    assign sel_pmr  = (reg_addr == A_PMR);
    assign sel_ack  = (reg_addr == A_ACK);
    assign sel_eoi  = (reg_addr == A_EOI);

    vif_pick #(
        .NUM_LR (NUM_LR),
        .IW     (IW),
        .PW     (PRIO_W)
    ) u_pick (
        .pend   (pend_vec),
        .prio   (prio_arr),
        .valid  (pick_valid),
        .idx    (pick_idx)
    );

    vif_eoi_match #(
        .NUM_LR (NUM_LR),
        .IW     (IW),
        .VW     (VID_W),
        .CW     (CPU_W)
    ) u_match (
        .live   (live_vec),
        .vid    (vid_arr),
        .cpu    (cpu_arr),
        .q_vid  (reg_wdata[VID_LSB +: VID_W]),
        .q_cpu  (reg_wdata[CPU_LSB +: CPU_W]),
        .hit    (eoi_hit),
        .idx    (eoi_idx)
    );

    assign ack_go = reg_rd && sel_ack && ctrl_en && pick_valid;
    assign eoi_go = reg_wr && sel_eoi && eoi_hit;

    vif_lr_bank #(
        .NUM_LR   (NUM_LR),
        .IW       (IW)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .hyp_we   (lr_wr_en),
        .hyp_idx  (lr_wr_idx),
        .hyp_data (lr_wr_data),
        .ack_go   (ack_go),
        .ack_idx  (pick_idx),
        .eoi_go   (eoi_go),
        .eoi_idx  (eoi_idx),
        .lr_q     (lr_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            pmr_q  <= '0;
        end else if (reg_wr) begin
            if (sel_ctrl) ctrl_q <= reg_wdata;
            if (sel_pmr)  pmr_q  <= reg_wdata[PRIO_W-1:0];
        end
    end

    always_comb begin
        rd_next = '0;
        if (sel_ctrl) begin
            rd_next = ctrl_q;
        end else if (sel_pmr) begin
            rd_next = {{(REG_W-PRIO_W){1'b0}}, pmr_q};
        end else if (sel_ack) begin
            rd_next = ack_go ? {{(REG_W-CPU_W-VID_W){1'b0}}, cpu_arr[pick_idx], vid_arr[pick_idx]}
                             : NO_INTR;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (reg_rd) begin
            rdata_q <= rd_next;
        end
    end

    assign reg_rdata  = rdata_q;
    assign lr_rd_data = lr_q[lr_rd_idx];

    vif_virq_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .pend_any (|pend_vec),
        .en       (ctrl_en),
        .virq     (virq)
    );

endmodule

// File: rtl/virq_ack_if_chk.sv
module virq_ack_if_chk
    import vif_pkg::*;
#(
    parameter int NUM_LR = 4,
    parameter int AW     = 4,
    parameter int IW     = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic [AW-1:0]       reg_addr,
    input logic                reg_rd,
    input logic                reg_wr,
    input logic [REG_W-1:0]    reg_rdata,
    input logic                lr_wr_en,
    input logic                virq,
    input logic                ctrl_en,
    input logic [NUM_LR-1:0]   pend_vec,
    input logic                pick_valid,
    input logic [IW-1:0]       pick_idx,
    input logic                eoi_hit,
    input logic [2*NUM_LR-1:0] lr_state_flat
);

    localparam logic [AW-1:0] C_ACK = AW'(OFS_ACK);
    localparam logic [AW-1:0] C_EOI = AW'(OFS_EOI);

    logic pend_any;
    assign pend_any = |pend_vec;

    assert_ack_nointr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && (reg_addr == C_ACK) && !ctrl_en) |=> (reg_rdata == NO_INTR));

    assert_ack_upper_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && (reg_addr == C_ACK)) |=> (reg_rdata[REG_W-1:13] == '0));

    assert_pick_is_pending_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pick_valid |-> pend_vec[pick_idx]);

    assert_pick_none_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !pick_valid |-> (pend_vec == '0));

    assert_eoi_miss_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && (reg_addr == C_EOI) && !eoi_hit && !lr_wr_en && !reg_rd)
        |=> $stable(lr_state_flat));

    assert_virq_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(virq) |-> $past(pend_any && ctrl_en));

    assert_virq_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (virq && pend_any) |=> virq);

    assert_virq_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (virq && !pend_any) |=> !virq);

endmodule

bind virq_ack_if virq_ack_if_chk #(
    .NUM_LR (NUM_LR),
    .AW     (AW),
    .IW     (IW)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .reg_addr      (reg_addr),
    .reg_rd        (reg_rd),
    .reg_wr        (reg_wr),
    .reg_rdata     (reg_rdata),
    .lr_wr_en      (lr_wr_en),
    .virq          (virq),
    .ctrl_en       (ctrl_en),
    .pend_vec      (pend_vec),
    .pick_valid    (pick_valid),
    .pick_idx      (pick_idx),
    .eoi_hit       (eoi_hit),
    .lr_state_flat (lr_state_flat)
);

// File: tb/virq_ack_if_tb.sv
`timescale 1ns/1ps
module virq_ack_if_tb;

    localparam int NUM_LR = 4;
    localparam int AW     = 4;
    localparam int IW     = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic          reg_rd = 1'b0;
    logic          reg_wr = 1'b0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          lr_wr_en = 1'b0;
    logic [IW-1:0] lr_wr_idx = '0;
    logic [31:0]   lr_wr_data = '0;
    logic [IW-1:0] lr_rd_idx = '0;
    logic [31:0]   lr_rd_data;
    logic          virq;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    virq_ack_if #(.NUM_LR(NUM_LR), .AW(AW)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_addr   (reg_addr),
        .reg_rd     (reg_rd),
        .reg_wr     (reg_wr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .lr_wr_en   (lr_wr_en),
        .lr_wr_idx  (lr_wr_idx),
        .lr_wr_data (lr_wr_data),
        .lr_rd_idx  (lr_rd_idx),
        .lr_rd_data (lr_rd_data),
        .virq       (virq)
    );

    // op: 0 entry load, 1 guest write, 2 guest read check, 3 entry read-back check
    // fields: op[73:72] addr/idx[71:68] data[67:36] expect[35:4] requirement[3:0]
    localparam int NV = 21;
    localparam logic [73:0] VEC [NV] = '{
        {2'd1, 4'h0, 32'h0000_0001, 32'h0000_0000, 4'd2},  // R2 enable
        {2'd2, 4'h0, 32'h0,         32'h0000_0001, 4'd2},  // R2
        {2'd1, 4'h4, 32'hFFFF_FFA5, 32'h0000_0000, 4'd2},  // R2 mask
        {2'd2, 4'h4, 32'h0,         32'h0000_0005, 4'd2},  // R2
        {2'd0, 4'h0, 32'h1500_0421, 32'h0,         4'd10}, // R10 prio 10
        {2'd0, 4'h1, 32'h1200_0835, 32'h0,         4'd10}, // R10 prio 4
        {2'd0, 4'h2, 32'h1200_1D00, 32'h0,         4'd10}, // R10 prio 4
        {2'd0, 4'h3, 32'h3F80_0007, 32'h0,         4'd10}, // R10 prio 31, pend+act
        {2'd3, 4'h1, 32'h0,         32'h1200_0835, 4'd10}, // R10 read-back
        {2'd2, 4'h8, 32'h0,         32'h0000_0835, 4'd5},  // R5 tie -> lower index
        {2'd2, 4'h8, 32'h0,         32'h0000_1D00, 4'd5},  // R5
        {2'd2, 4'h8, 32'h0,         32'h0000_0421, 4'd5},  // R5
        {2'd2, 4'h8, 32'h0,         32'h0000_0007, 4'd4},  // R4
        {2'd3, 4'h3, 32'h0,         32'h2F80_0007, 4'd4},  // R4 state 3 -> 2
        {2'd2, 4'h8, 32'h0,         32'h0000_03FF, 4'd3},  // R3 nothing pending
        {2'd1, 4'hC, 32'h0000_0835, 32'h0,         4'd6},  // R6
        {2'd3, 4'h1, 32'h0,         32'h0200_0835, 4'd6},  // R6
        {2'd1, 4'hC, 32'h0000_0C21, 32'h0,         4'd7},  // R7 cpu mismatch
        {2'd3, 4'h0, 32'h0,         32'h2500_0421, 4'd7},  // R7
        {2'd1, 4'hC, 32'h0000_1D00, 32'h0,         4'd6},  // R6
        {2'd3, 4'h2, 32'h0,         32'h0200_1D00, 4'd6}   // R6
    };

    task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL R%0d actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic hyp_wr(input logic [IW-1:0] idx, input logic [31:0] d);
        lr_wr_en = 1'b1; lr_wr_idx = idx; lr_wr_data = d;
        tick();
        lr_wr_en = 1'b0;
    endtask

    task automatic guest_wr(input logic [AW-1:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic guest_rd(input logic [AW-1:0] a, output logic [31:0] d);
        reg_rd = 1'b1; reg_addr = a;
        tick();
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic lr_peek(input logic [IW-1:0] idx, output logic [31:0] d);
        lr_rd_idx = idx;
        #0.5;
        d = lr_rd_data;
    endtask

    initial begin
        logic [73:0] v;
        logic [31:0] r;
        repeat (3) @(negedge clk);

        // R1: reset state
        check(1, {31'b0, virq}, 32'h0);
        check(1, reg_rdata, 32'h0);
        for (int i = 0; i < NUM_LR; i++) begin
            lr_peek(IW'(i), r);
            check(1, r, 32'h0);
        end
        rst_n = 1'b1;
        tick();
        guest_rd(4'h0, r);
        check(1, r, 32'h0);

        for (int k = 0; k < NV; k++) begin
            v = VEC[k];
            case (v[73:72])
                2'd0: hyp_wr(v[69:68], v[67:36]);
                2'd1: guest_wr(v[71:68], v[67:36]);
                2'd2: begin guest_rd(v[71:68], r); check(int'(v[3:0]), r, v[35:4]); end
                default: begin lr_peek(v[69:68], r); check(int'(v[3:0]), r, v[35:4]); end
            endcase
        end

        // R8: rise one cycle after an entry goes pending with enable set
        check(8, {31'b0, virq}, 32'h0);
        hyp_wr(2'd1, 32'h1200_0835);
        check(8, {31'b0, virq}, 32'h0);
        tick();
        check(8, {31'b0, virq}, 32'h1);

        // R9: disabling does not withdraw while pending
        guest_wr(4'h0, 32'h0);
        tick();
        check(9, {31'b0, virq}, 32'h1);
        // R3: disabled acknowledge returns 1023, entry untouched
        guest_rd(4'h8, r);
        check(3, r, 32'h0000_03FF);
        lr_peek(2'd1, r);
        check(3, r, 32'h1200_0835);

        // R9: fall one cycle after nothing pending
        hyp_wr(2'd1, 32'h0);
        check(9, {31'b0, virq}, 32'h1);
        tick();
        check(9, {31'b0, virq}, 32'h0);

        // R8: pending but disabled stays low; enabling raises one cycle later
        hyp_wr(2'd2, 32'h1200_1D00);
        tick(); tick();
        check(8, {31'b0, virq}, 32'h0);
        guest_wr(4'h0, 32'h1);
        check(8, {31'b0, virq}, 32'h0);
        tick();
        check(8, {31'b0, virq}, 32'h1);

        // R10: load and acknowledge to the same entry in one cycle
        reg_rd = 1'b1; reg_addr = 4'h8;
        lr_wr_en = 1'b1; lr_wr_idx = 2'd2; lr_wr_data = 32'h1200_0ABC;
        tick();
        reg_rd = 1'b0; lr_wr_en = 1'b0;
        check(10, reg_rdata, 32'h0000_1D00);
        lr_peek(2'd2, r);
        check(10, r, 32'h1200_0ABC);

        // R6: retire the reloaded entry, then R9 fall
        guest_wr(4'hC, 32'h0000_0ABC);
        lr_peek(2'd2, r);
        check(6, r, 32'h0200_0ABC);
        tick();
        check(9, {31'b0, virq}, 32'h0);

        // R7: fields match but entry already invalid
        guest_wr(4'hC, 32'h0000_0ABC);
        lr_peek(2'd2, r);
        check(7, r, 32'h0200_0ABC);
        lr_peek(2'd0, r);
        check(7, r, 32'h2500_0421);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule